// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one read or write burst inside a synchronous DRAM bank. A command pulse loads a start column, a burst-length code and an ordering choice. From the next cycle on, the block presents one column address per clock, together with a valid flag. It raises a done flag alongside the final address of a finite burst.

Two orderings are available. Sequential ordering counts up inside the aligned block that holds the start column. Interleaved ordering walks that block by XOR of a running index into the start column. A full-row setting counts through the whole 256-column row, wrapping past the top, until it is stopped. A stop pulse ends a burst on any cycle. A fresh command replaces a running burst on any cycle with no spacing rule.

The block sits between the command decoder and the column decoder. CAS latency and the data path are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `burst_done` are low and stay low until a command is taken.
- R2: When `cmd_start` is high at a rising edge, the next cycle shows `col_valid` high and `col_addr` equal to the sampled `start_col`. Each later cycle of the burst shows the next address.
- R3: With `ilv_mode` low and a burst length of N (1, 2, 4 or 8), the k-th address keeps the bits above log2(N) of the start column. Its low log2(N) bits equal (start low bits + k) mod N, so the burst wraps inside its aligned block.
- R4: With `ilv_mode` high and a burst length of N (1, 2, 4 or 8), the k-th address is the start column with its low log2(N) bits XORed with k.
- R5: `len_code` selects the burst length. Value 0 gives 1 address, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full row. The unused values 4, 5 and 6 behave as length 1.
- R6: `burst_done` is high only together with the last address of a finite burst. In the cycle after it, `col_valid` is low unless a new command was taken.
- R7: A length-1 burst yields exactly one address, and `burst_done` is high in that same cycle.
- R8: A full-row burst counts up by one per cycle modulo 256, wrapping from 255 to 0. It never raises `burst_done` and runs until it is stopped or replaced.
- R9: A full-row code with `ilv_mode` high runs as a sequential full-row burst.
- R10: `cmd_stop` high at a rising edge makes `col_valid` low from the next cycle. It has no effect when no burst runs. When `cmd_start` is high at the same edge, the start wins.
- R11: A command taken during a burst discards the old burst. The next cycle shows the new start column, and the new length and ordering apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Take a new burst command this cycle |
| cmd_stop | input | 1 | End the running burst |
| start_col | input | 8 | Start column of the new burst |
| len_code | input | 3 | Burst length code (see R5) |
| ilv_mode | input | 1 | 1 = interleaved ordering, 0 = sequential |
| col_valid | output | 1 | `col_addr` holds a burst address this cycle |
| col_addr | output | 8 | Current column address |
| burst_done | output | 1 | This is the last address of a finite burst |

## Verification
The hardest case to reach is a new command arriving in the very cycle the old burst shows its final address. The same holds for a command landing together with a stop, where the block must drop the done path and load fresh state. The driver issues the next command on the exact negative edge at which the chosen number of old addresses has been queued, so restarts and stops can be placed at any burst position, including the last. Full-row wrap is reached by starting a few columns below 255 and letting the burst run past the top before a stop.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_1   = 3'd0;
  localparam logic [LEN_CODE_W-1:0] LEN_2   = 3'd1;
  localparam logic [LEN_CODE_W-1:0] LEN_4   = 3'd2;
  localparam logic [LEN_CODE_W-1:0] LEN_8   = 3'd3;
  localparam logic [LEN_CODE_W-1:0] LEN_ROW = 3'd7;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv_req,
  output logic [COL_W-1:0]      len_mask,
  output logic                  full_row,
  output logic                  ilv_eff
);
  // Mask of the address bits that move during a burst of the coded length.
  function automatic logic [COL_W-1:0] code_to_mask(input logic [LEN_CODE_W-1:0] c);
    case (c)
      LEN_2:   return COL_W'(1);
      LEN_4:   return COL_W'(3);
      LEN_8:   return COL_W'(7);
      LEN_ROW: return '1;
      default: return '0;  // LEN_1 and reserved codes
    endcase
  endfunction

  assign len_mask = code_to_mask(len_code);
  assign full_row = (len_code == LEN_ROW);
  // R9: interleaving is not offered for a full row
  assign ilv_eff  = ilv_req && !full_row;
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             ilv_in,
  output logic             active,
  output logic             last,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] step_q,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q
);
  logic full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      step_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      base_q <= start_col;
      step_q <= '0;
      mask_q <= mask_in;
      full_q <= full_in;
      ilv_q  <= ilv_in;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      step_q <= step_q + 1'b1;
    end
  end

  // Finite burst reaches its final index; a full row never ends by itself.
  assign last = active && !full_q && (step_q == mask_q);

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && step_q == '0 && base_q == $past(start_col)));
  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !active);
  // R6
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !active);
  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && !start && !stop) |=> (active && step_q == $past(step_q) + 1'b1));
  // R8
  row_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && full_q) |-> !last);
  // R7
  single_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !full_q && mask_q == '0) |-> last);
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] step,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  // Sequential count; carries out of the masked low field only land in
  // bits that the mask discards, so the field wraps modulo the length.
  function automatic logic [COL_W-1:0] seq_sum(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] s);
    return b + s;
  endfunction

  function automatic logic [COL_W-1:0] ilv_mix(input logic [COL_W-1:0] b,
                                               input logic [COL_W-1:0] s);
    return b ^ s;
  endfunction

  logic [COL_W-1:0] sum_w;
  logic [COL_W-1:0] mix_w;
  assign sum_w = seq_sum(base, step);
  assign mix_w = ilv_mix(base, step);

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign addr[i] = mask[i] ? (ilv ? mix_w[i] : sum_w[i]) : base[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_start,
  input  logic                  cmd_stop,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv_mode,
  output logic                  col_valid,
  output logic [COL_W-1:0]      col_addr,
  output logic                  burst_done
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ilv;
  logic             run_w;
  logic             last_w;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] step_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .len_code (len_code),
    .ilv_req  (ilv_mode),
    .len_mask (dec_mask),
    .full_row (dec_full),
    .ilv_eff  (dec_ilv)
  );

  burst_step_ctr #(.COL_W(COL_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_start),
    .stop      (cmd_stop),
    .start_col (start_col),
    .mask_in   (dec_mask),
    .full_in   (dec_full),
    .ilv_in    (dec_ilv),
    .active    (run_w),
    .last      (last_w),
    .base_q    (base_q),
    .step_q    (step_q),
    .mask_q    (mask_q),
    .ilv_q     (ilv_q)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .step (step_q),
    .mask (mask_q),
    .ilv  (ilv_q),
    .addr (col_addr)
  );

  assign col_valid  = run_w;
  assign burst_done = last_w;

  // R6
  done_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> col_valid);
  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !cmd_start && !cmd_stop && !burst_done)
      |=> ((col_addr & ~mask_q) == ($past(col_addr) & ~mask_q)));
  // R11
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (col_valid && col_addr == $past(start_col)));
endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic       cmd_stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       ilv_mode = 1'b0;
  logic       col_valid;
  logic [7:0] col_addr;
  logic       burst_done;

  always #5 clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .start_col(start_col), .len_code(len_code), .ilv_mode(ilv_mode),
    .col_valid(col_valid), .col_addr(col_addr), .burst_done(burst_done)
  );

  typedef struct {
    logic [7:0] a;
    logic       d;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_addr(input int s, input logic [2:0] c,
                                          input logic ilv, input int k);
    int n;
    int blk;
    n = len_of(c);
    if (c == 3'd7) return 8'((s + k) % 256);
    if (ilv) return 8'(s ^ k);
    blk = s - (s % n);
    return 8'(blk + ((s % n) + k) % n);
  endfunction

  // Monitor: compare each produced address against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (col_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected address: actual %h expected none", col_addr);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          if (col_addr !== e.a || burst_done !== e.d) begin
            errors++;
            $display("FAIL %s addr/done actual %h/%b expected %h/%b",
                     e.tag, col_addr, burst_done, e.a, e.d);
          end
        end
      end else if (burst_done) begin
        checks++;
        errors++;
        $display("FAIL R6 done without valid: actual 1 expected 0");
      end
    end
  end

  // Driver: queue the first m addresses, issue the command, wait until the
  // m-th address is on the outputs.
  task automatic issue(input logic [7:0] col, input logic [2:0] c, input logic ilv,
                       input int m, input logic with_stop, input string tag);
    int n;
    n = len_of(c);
    for (int k = 0; k < m && k < n; k++) begin
      item_t e;
      e.a = exp_addr(col, c, ilv, k);
      e.d = (c != 3'd7) && (k == n - 1);
      e.tag = tag;
      exp_q.push_back(e);
    end
    start_col = col; len_code = c; ilv_mode = ilv;
    cmd_start = 1'b1; cmd_stop = with_stop;
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0;
    repeat (m - 1) @(negedge clk);
  endtask

  task automatic stop_now();
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || col_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s pending items actual %0d/valid %b expected 0/0",
               tag, exp_q.size(), col_valid);
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (col_valid !== 1'b0 || burst_done !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b%b expected 00", col_valid, burst_done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (col_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle after reset actual %b expected 0", col_valid);
    end

    issue(8'h15, 3'd2, 1'b0, 4, 1'b0, "R3_seq4");       drain("R3");
    issue(8'h2D, 3'd3, 1'b0, 8, 1'b0, "R3_R6_seq8");    drain("R6");
    issue(8'h2D, 3'd3, 1'b1, 8, 1'b0, "R4_ilv8");       drain("R4");
    issue(8'h0E, 3'd2, 1'b1, 4, 1'b0, "R4_ilv4");       drain("R4");
    issue(8'h41, 3'd1, 1'b0, 2, 1'b0, "R5_len2");       drain("R5");
    issue(8'h99, 3'd0, 1'b0, 1, 1'b0, "R7_len1");       drain("R7");
    issue(8'h33, 3'd5, 1'b0, 1, 1'b0, "R5_reserved");   drain("R5");
    issue(8'hFA, 3'd7, 1'b0, 12, 1'b0, "R8_row_wrap");
    stop_now();                                          drain("R8");
    issue(8'hFC, 3'd7, 1'b1, 6, 1'b0, "R9_row_ilv");
    stop_now();                                          drain("R9");
    // R11: replace mid burst, then replace on the final address
    issue(8'h10, 3'd3, 1'b0, 3, 1'b0, "R11_old");
    issue(8'h83, 3'd2, 1'b1, 4, 1'b0, "R11_new");
    issue(8'h57, 3'd1, 1'b0, 2, 1'b0, "R11_after_last"); drain("R11");
    // R10: stop mid burst
    issue(8'h60, 3'd3, 1'b0, 2, 1'b0, "R10_stop_mid");
    stop_now();                                          drain("R10");
    // R10: start wins over a simultaneous stop
    issue(8'h71, 3'd1, 1'b0, 2, 1'b1, "R10_start_wins"); drain("R10");
    // R10: stop while idle does nothing
    stop_now();                                          drain("R10");
    issue(8'h05, 3'd0, 1'b0, 1, 1'b0, "R10_idle_stop");  drain("R10");
    // back-to-back short bursts
    issue(8'h00, 3'd1, 1'b0, 2, 1'b0, "R2_b2b_a");
    issue(8'h02, 3'd1, 1'b1, 2, 1'b0, "R2_b2b_b");       drain("R2");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule